// File: doc/BRIEF.md
# Shared Interrupt Request Collector

This block gathers four interrupt sources into sticky pending flags and drives one shared, active-low interrupt line. Two sources are external guest request pins. Each pin passes through a two-stage synchroniser, and a request is taken on the pin's rising edge. The other two sources are single-cycle pulses from inside the chip: a step event from the code buffer pointer and a done event from the compression/decompression engine.

Software reads a status word to find pending requests and clears them by writing ones. Enable bits mask each source onto the shared line, and one master enable gates the line as a whole. A pending flag records its source whether or not that source is enabled, so polling software can still see the event. The register port is a plain synchronous write strobe with a combinational read. It has two word addresses: status at offset 0x03C and enables at offset 0x040.

Top module: `irq_hub`

## Requirements
- R1: After reset all pending flags and all enables are 0, and `irq_n_o` is 1.
- R2: A write to the status offset (0x03C) clears each pending flag whose write-data bit is 1 and leaves alone each flag whose bit is 0. The flags sit at bit 30 (guest pin 1), bit 29 (guest pin 0), bit 28 (code step) and bit 27 (codec done).
- R3: When a source event and a clearing write hit the same flag in the same clock cycle, the flag ends up at 1.
- R4: A rising edge on a guest pin sets its flag on the third rising clock edge after the pin change is first sampled. A pin that stays high, or a falling edge, sets nothing further.
- R5: A one-cycle pulse on `code_step_i` or `codec_done_i` sets the matching flag at the next clock edge.
- R6: Pending flags latch their events whatever the state of the enable bits.
- R7: `irq_n_o` is registered. One cycle after the state changes, it is 0 exactly when the master enable is 1 and at least one pending flag has its enable set. Otherwise it is 1, and it stays 0 for as long as that condition holds.
- R8: The enable word at offset 0x040 holds the master enable at bit 31 and the source enables at bits 30..27, in the same order as the status flags. It reads back exactly as written. All bits of either word outside these fields read 0.
- R9: A write to any address other than the two offsets changes no state, and reading such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| guest_pin_i | input | 2 | Asynchronous guest request pins (index 1 = guest 1) |
| code_step_i | input | 1 | Code buffer step event pulse |
| codec_done_i | input | 1 | Compression/decompression done event pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| irq_n_o | output | 1 | Shared interrupt line, active low |

## Verification
All 16 clear masks are applied to a fully pending status word. This separates per-bit write-one-to-clear from a clear of the whole word or a clear on zeros. Every pending pattern is then crossed with all 32 enable words. Computing the line arithmetically for each pair catches a missing master gate, a swapped field, or a wrong AND/OR reduction. Further directed cases cover the following:
- an event and a clear landing in the same cycle, to expose clear-priority;
- held-high and falling guest pins, to tell edge detection from level detection;
- writes to an unmapped address.

// File: rtl/irq_hub_pkg.sv
// Package: shared constants and types for the interrupt collector.
// Assumes four sources in a fixed order: index 0 codec done, 1 code step,
// 2 guest pin 0, 3 guest pin 1; source i lives at word bit FIELD_LSB + i.
package irq_hub_pkg;
    localparam int NUM_SRC    = 4;
    localparam int NUM_GUEST  = 2;
    localparam int DATA_W     = 32;
    localparam int FIELD_LSB  = 27;
    localparam int GLOBAL_BIT = 31;
    localparam int SRC_CODEC  = 0;
    localparam int SRC_STEP   = 1;
    localparam int SRC_GUEST0 = 2;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [DATA_W-1:0]  word_t;
endpackage

// File: rtl/irq_pin_sync.sv
// Module: synchronises one asynchronous pin and emits a one-cycle pulse on
// each rising edge seen after the synchroniser.
// Assumes the pin stays at each level for at least one clock period.
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the pin through the synchroniser chain and keep the last value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // Rising edge: synchronised level high now, low one cycle ago.
    always_comb begin
        rise_o = sync_q[STAGES-1] & ~prev_q;
    end
endmodule

// File: rtl/irq_sticky_bank.sv
// Module: bank of sticky pending flags, write-one-to-clear with set priority.
// Assumes set_i pulses and clr_i is a one-cycle mask from a register write.
module irq_sticky_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    // Per-bit update: a set beats a clear that lands in the same cycle.
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_i[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_i[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_reg_port.sv
// Module: register decode. Holds the enable word, turns status writes into
// clear masks and builds the read data.
// Assumes a single-cycle write strobe and a combinational read.
module irq_reg_port
    import irq_hub_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  STAT_OFS = 8'h3C,
    parameter logic [7:0]  EN_OFS   = 8'h40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  word_t             wdata_i,
    input  src_vec_t          flag_i,
    output src_vec_t          clr_o,
    output src_vec_t          en_src_o,
    output logic              en_glob_o,
    output word_t             rdata_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] EN_A   = ADDR_W'(EN_OFS);

    logic     hit_stat;
    logic     hit_en;
    src_vec_t en_src_q;
    logic     en_glob_q;
    src_vec_t wfield;
    logic     unused_wbits;

    assign hit_stat     = (addr_i == STAT_A);
    assign hit_en       = (addr_i == EN_A);
    assign wfield       = wdata_i[FIELD_LSB +: NUM_SRC];
    assign unused_wbits = ^{wdata_i[FIELD_LSB-1:0]};

    // Clear mask exists only for the cycle of a status write.
    always_comb begin
        clr_o = (we_i && hit_stat) ? wfield : '0;
    end

    // Enable word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_src_q  <= '0;
            en_glob_q <= 1'b0;
        end else if (we_i && hit_en) begin
            en_src_q  <= wfield;
            en_glob_q <= wdata_i[GLOBAL_BIT];
        end
    end

    // Read mux; reserved bits and unmapped addresses read zero.
    always_comb begin
        rdata_o = '0;
        if (hit_stat) begin
            rdata_o[FIELD_LSB +: NUM_SRC] = flag_i;
        end else if (hit_en) begin
            rdata_o[FIELD_LSB +: NUM_SRC] = en_src_q;
            rdata_o[GLOBAL_BIT]           = en_glob_q;
        end
    end

    assign en_src_o  = en_src_q;
    assign en_glob_o = en_glob_q;
endmodule

// File: rtl/irq_hub.sv
// Module: top of the interrupt collector. Synchronises the guest pins, merges
// them with the internal pulses into sticky flags, and drives a registered
// active-low shared interrupt line.
// Assumes the internal pulse inputs are synchronous to clk.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  STAT_OFS    = 8'h3C,
    parameter logic [7:0]  EN_OFS      = 8'h40,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_GUEST-1:0] guest_pin_i,
    input  logic                 code_step_i,
    input  logic                 codec_done_i,
    input  logic                 reg_we_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic                 irq_n_o
);
    logic [NUM_GUEST-1:0] guest_rise;
    src_vec_t             src_evt;
    src_vec_t             clr_mask;
    src_vec_t             stat_q;
    src_vec_t             en_src;
    logic                 en_glob;
    logic                 irq_n_q;

    // One synchroniser and edge detector per guest pin.
    for (genvar g = 0; g < NUM_GUEST; g++) begin : g_guest
        irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (guest_pin_i[g]),
            .rise_o (guest_rise[g])
        );
    end

    // Gather all source events into the fixed source order.
    always_comb begin
        src_evt                              = '0;
        src_evt[SRC_CODEC]                   = codec_done_i;
        src_evt[SRC_STEP]                    = code_step_i;
        src_evt[SRC_GUEST0 +: NUM_GUEST]     = guest_rise;
    end

    irq_sticky_bank #(.N(NUM_SRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (src_evt),
        .clr_i  (clr_mask),
        .flag_o (stat_q)
    );

    irq_reg_port #(
        .ADDR_W   (ADDR_W),
        .STAT_OFS (STAT_OFS),
        .EN_OFS   (EN_OFS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (reg_we_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .flag_i    (stat_q),
        .clr_o     (clr_mask),
        .en_src_o  (en_src),
        .en_glob_o (en_glob),
        .rdata_o   (reg_rdata_o)
    );

    // Registered shared line: low while any enabled flag is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n_q <= 1'b1;
        end else begin
            irq_n_q <= ~(en_glob & (|(stat_q & en_src)));
        end
    end

    assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_hub_chk.sv
// Module: assertion checker bound to irq_hub; observes events, flags,
// enables and the register port.
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [7:0] STAT_OFS = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  src_vec_t          evt,
    input  src_vec_t          stat,
    input  src_vec_t          en_src,
    input  logic              en_glob,
    input  logic              irq_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  word_t             rdata
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam word_t RSVD = ~((word_t'((1 << NUM_SRC) - 1) << FIELD_LSB)
                               | (word_t'(1) << GLOBAL_BIT));

    // R3: an event always leaves its flag set on the next cycle.
    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat & $past(evt)) == $past(evt)));

    // R2: a status write clears every written-one bit that had no event.
    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == STAT_A) |=>
        ((stat & $past(wdata[FIELD_LSB +: NUM_SRC] & ~evt)) == '0));

    // R6: a flag only rises because of an event, enabled or not.
    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~stat)) |=> ((stat & ~$past(stat) & ~$past(evt)) == '0));

    // R7: the line follows the masked pending state with one cycle of lag.
    p_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_glob || !en_glob) |=>
        (irq_n == !($past(en_glob) && |($past(stat & en_src)))));

    // R8: reserved bit positions never read as one.
    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == STAT_A) |-> ((rdata & RSVD) == '0));
endmodule

bind irq_hub irq_hub_chk #(
    .ADDR_W   (ADDR_W),
    .STAT_OFS (STAT_OFS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (src_evt),
    .stat    (stat_q),
    .en_src  (en_src),
    .en_glob (en_glob),
    .irq_n   (irq_n_o),
    .we      (reg_we_i),
    .addr    (reg_addr_i),
    .wdata   (reg_wdata_i),
    .rdata   (reg_rdata_o)
);

// File: tb/irq_hub_test.sv
module irq_hub_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_STAT = 8'h3C;
    localparam logic [7:0] A_EN   = 8'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  guest_pin = '0;
    logic        code_step = 1'b0;
    logic        codec_done = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_hub uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .guest_pin_i  (guest_pin),
        .code_step_i  (code_step),
        .codec_done_i (codec_done),
        .reg_we_i     (we),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .irq_n_o      (irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    // Load a pending pattern: bit0 codec, bit1 step, bit2 guest0, bit3 guest1.
    task automatic load_stat(input logic [3:0] s);
        wr(A_STAT, 32'h7800_0000);
        @(negedge clk);
        codec_done = s[0]; code_step = s[1]; guest_pin = s[3:2];
        @(negedge clk);
        codec_done = 1'b0; code_step = 1'b0;
        @(negedge clk);
        guest_pin = 2'b00;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, r); check("R1 status", r, 32'h0);
        rd(A_EN, r);   check("R1 enable", r, 32'h0);
        check("R1 irq_n", {31'b0, irq_n}, 32'h1);

        // R5/R6: internal pulses latch with all enables off, next edge
        @(negedge clk); code_step = 1'b1;
        @(negedge clk); code_step = 1'b0; addr = A_STAT;
        #1 check("R5 step sets next edge", rdata, 32'h1000_0000);
        @(negedge clk); codec_done = 1'b1;
        @(negedge clk); codec_done = 1'b0;
        #1 check("R6 codec latches while disabled", rdata, 32'h1800_0000);
        check("R6 line idle while disabled", {31'b0, irq_n}, 32'h1);
        wr(A_STAT, 32'h1800_0000);

        // R4: guest edge timing, held level, falling edge
        @(negedge clk); guest_pin[0] = 1'b1; addr = A_STAT;
        @(negedge clk); #1 check("R4 not yet after 1 edge", rdata, 32'h0);
        @(negedge clk); #1 check("R4 not yet after 2 edges", rdata, 32'h0);
        @(negedge clk); #1 check("R4 set after 3 edges", rdata, 32'h2000_0000);
        wr(A_STAT, 32'h2000_0000);
        repeat (5) @(negedge clk);
        rd(A_STAT, r); check("R4 held high no reset", r, 32'h0);
        guest_pin[0] = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_STAT, r); check("R4 falling edge ignored", r, 32'h0);
        @(negedge clk); guest_pin[1] = 1'b1;
        repeat (4) @(negedge clk);
        guest_pin[1] = 1'b0;
        rd(A_STAT, r); check("R4 guest1 edge", r, 32'h4000_0000);

        // R2: every clear mask on a full pending word
        for (int m = 0; m < 16; m++) begin
            load_stat(4'hF);
            wr(A_STAT, 32'(m) << 27 | 32'h8000_0000 | 32'h07FF_FFFF);
            rd(A_STAT, r);
            check("R2 w1c mask", r, 32'(4'hF & ~m[3:0]) << 27);
        end

        // R3: event and clear in the same cycle
        load_stat(4'b0001);
        @(negedge clk);
        we = 1'b1; addr = A_STAT; wdata = 32'h1800_0000; code_step = 1'b1;
        @(negedge clk);
        we = 1'b0; code_step = 1'b0;
        #1 check("R3 set wins over clear", rdata, 32'h1000_0000);

        // R7/R8: every pending pattern against every enable word
        for (int s = 0; s < 16; s++) begin
            load_stat(4'(s));
            rd(A_STAT, r); check("R8 status layout", r, 32'(s) << 27);
            for (int e = 0; e < 32; e++) begin
                wr(A_EN, (32'(e) << 27) | 32'h07FF_FFFF);
                rd(A_EN, r); check("R8 enable readback", r, 32'(e) << 27);
                check("R7 line", {31'b0, irq_n},
                      {31'b0, !(e[4] && ((s & e[3:0]) != 0))});
            end
        end

        // R7: line releases once the enabled flag is cleared
        wr(A_EN, 32'hF800_0000);
        load_stat(4'b0010);
        check("R7 line low while pending", {31'b0, irq_n}, 32'h0);
        wr(A_STAT, 32'h1000_0000);
        @(negedge clk);
        check("R7 line high after clear", {31'b0, irq_n}, 32'h1);

        // R9: unmapped address
        wr(A_EN, 32'h9000_0000);
        load_stat(4'b0100);
        wr(8'h44, 32'hFFFF_FFFF);
        rd(8'h44, r);   check("R9 unmapped reads zero", r, 32'h0);
        rd(A_EN, r);    check("R9 enable untouched", r, 32'h9000_0000);
        rd(A_STAT, r);  check("R9 status untouched", r, 32'h2000_0000);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule